// File: doc/BRIEF.md
# Secure Shared-Interrupt Configuration Register Bank

This block keeps the per-line configuration and status of a parameterised number of shared interrupt lines and exposes it through a byte-addressed register window. Each line has a group bit, a group-modifier bit, enable, pending and active bits, an 8-bit priority, a trigger-type bit, a 2-bit non-secure access level and a 64-bit routing word. Every access is 4 or 8 bytes wide and is tagged secure or non-secure. A global `sec_off` input says whether the two security states are merged (1) or kept apart (0). Line numbers below 32 are reserved for other logic and have no storage here. Line N is reported at bit N-32 of the line-indexed ports.

A line counts as non-secure group 1 exactly when its group bit is 1. Otherwise it is a secure line. With `sec_off` low, a non-secure access to a secure line sees a filtered view: the line's bits read as zero and ignore writes, unless its access level grants the right. Priorities seen from the non-secure side are shown in a shifted form. Enable, pending and active are changed through paired set and clear windows. Hardware can also raise or drop pending through per-line inputs.

The access port has no handshake. Reads are combinational from the address, size and security inputs. A write is accepted in every cycle that `acc_write` is high and takes effect at that clock edge. There is no back-pressure. The pending, enabled and active vectors are driven out for a neighbouring arbiter.

Top module: `irq_cfg_regs`

## Requirements
- R1: After reset, all group, group-modifier, enable, pending, active and access-level bits are 0, every priority is 8'hAA, and every trigger bit is 0 (level).
- R2: Windows with 1 bit per line (line = first line + bit index, first line = 8 × byte offset) are: set-enable at 0x100, clear-enable at 0x180, set-pending at 0x200, clear-pending at 0x280, set-active at 0x300 and clear-active at 0x380. Writing 1 to a bit sets or clears the bit; writing 0 does nothing. Both windows of a pair read back the current state.
- R3: The group window is at 0x080 (1 bit per line) and the group-modifier window is at 0xD00 (1 bit per line). The access-level window is at 0xE00, 2 bits per line at bits [2k+1:2k], with first line = 4 × byte offset. With `sec_off` low, a non-secure access to the group window reads 0 and ignores writes. The group-modifier and access-level windows read 0 and ignore writes for any non-secure access, and for any access while `sec_off` is high.
- R4: When a non-secure access reaches a secure line with `sec_off` low, the line's bit reads 0 and ignores writes unless its access level is high enough. Set-pending needs level ≥1. Clear-pending and both active windows need ≥2. The routing word needs 3. Enable and trigger are always blocked.
- R5: Priority window at 0x400, one byte per line (line = 0x400 + line number). With `sec_off` low, a non-secure access skips secure lines. For group-1 lines it reads {prio[6:0],0} and writes 8'h80 | (data >> 1).
- R6: Trigger window at 0xC00, 2 bits per line with first line = 4 × byte offset. Only the upper bit of each pair is stored; 1 means edge and 0 means level.
- R7: Routing words are at 0x6000 + 8 × line. An 8-byte access covers the whole word. A 4-byte access with address[2:0] = 0 covers bits [31:0], and any other 4-byte access covers bits [63:32].
- R8: An access whose first line is below 32 reads 0 and writes nothing, even for lines within its span that are 32 or above. Lines at or above NUM_LINES are ignored.
- R9: A write takes effect at the clock edge where `acc_write` is high. In the same cycle, `line_assert` sets pending and `line_deassert` clears it, with assert winning. A software set or clear of that pending bit in the same cycle overrides both.
- R10: Addresses outside every window, such as the legacy target range at 0x800, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_off | input | 1 | 1 = single security state |
| acc_write | input | 1 | Write strobe for this cycle |
| acc_addr | input | 16 | Byte address of the access |
| acc_size8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| acc_secure | input | 1 | Access is from the secure side |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Combinational read data |
| line_assert | input | NUM_LINES-32 | Per-line hardware set of pending |
| line_deassert | input | NUM_LINES-32 | Per-line hardware clear of pending |
| irq_pending | output | NUM_LINES-32 | Pending bits |
| irq_enabled | output | NUM_LINES-32 | Enable bits |
| irq_active | output | NUM_LINES-32 | Active bits |

## Verification
The hardest state to reach from the ports is a non-secure access to a secure line that holds an intermediate access level. At that point the same line is visible in the set-pending window but hidden from clear-pending, enable and routing. The stimulus first uses secure writes to make one neighbouring line non-secure group 1 and to give another line level 1. It then probes every window from the non-secure side. The check confirms that blocked writes had no effect by reading back from the secure side. Collisions between hardware pending events and software writes in the same cycle are driven by raising the line inputs around a single write strobe.

// File: rtl/irqcfg_pkg.sv
package irqcfg_pkg;
  localparam int FIRST_SHARED = 32;

  localparam logic [15:0] GRP_BASE = 16'h0080;
  localparam logic [15:0] SEN_BASE = 16'h0100;
  localparam logic [15:0] CEN_BASE = 16'h0180;
  localparam logic [15:0] SPD_BASE = 16'h0200;
  localparam logic [15:0] CPD_BASE = 16'h0280;
  localparam logic [15:0] SAC_BASE = 16'h0300;
  localparam logic [15:0] CAC_BASE = 16'h0380;
  localparam logic [15:0] PRI_BASE = 16'h0400;
  localparam logic [15:0] TRG_BASE = 16'h0C00;
  localparam logic [15:0] GMD_BASE = 16'h0D00;
  localparam logic [15:0] NSL_BASE = 16'h0E00;
  localparam logic [15:0] RTE_BASE = 16'h6000;
  localparam logic [15:0] RTE_END  = 16'h8000;

  localparam int SPAN_BIT = 128;
  localparam int SPAN_TWO = 256;
  localparam int SPAN_PRI = 1024;

  // Access level needed by a non-secure access to a secure line
  localparam int NEED_SETPEND = 1;
  localparam int NEED_PENDACT = 2;
  localparam int NEED_ROUTE   = 3;
  localparam int NEED_NEVER   = 4;

  typedef struct packed {
    logic        grp;
    logic        gmod;
    logic        en;
    logic        pend;
    logic        act;
    logic        edge_trig;
    logic [1:0]  lvl;
    logic [7:0]  prio;
    logic [63:0] route;
  } irq_state_t;

  // Lane of line `id` inside an access, or -1 when the access misses it
  function automatic int lane_of(input logic [15:0] addr, input logic [15:0] base,
                                 input int span, input int per_byte,
                                 input logic size8, input int id);
    int off, first, lanes, res;
    res   = -1;
    off   = int'(addr) - int'(base);
    first = off * per_byte;
    lanes = (size8 ? 8 : 4) * per_byte;
    if (off >= 0 && off < span && first >= FIRST_SHARED &&
        id >= first && id < first + lanes)
      res = id - first;
    return res;
  endfunction

  function automatic logic ns_blocked(input logic sec_off, input logic secure,
                                      input logic grp1, input logic [1:0] lvl,
                                      input int need);
    return !sec_off && !secure && !grp1 && (int'(lvl) < need);
  endfunction
endpackage

// File: rtl/irq_cell.sv
module irq_cell
  import irqcfg_pkg::*;
#(
  parameter int ID = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_off,
  input  logic        wr_en,
  input  logic [15:0] addr,
  input  logic        size8,
  input  logic        secure,
  input  logic [63:0] wdata,
  input  logic        hw_set,
  input  logic        hw_clr,
  output irq_state_t  st
);
  irq_state_t nxt;
  logic ns_view, grp1, rte_hit, sw_pset, sw_pclr;
  int k_grp, k_sen, k_cen, k_spd, k_cpd, k_sac, k_cac, k_pri, k_trg, k_gmd, k_nsl;

  always_comb begin
    ns_view = !sec_off && !secure;
    grp1    = st.grp;
    k_grp = lane_of(addr, GRP_BASE, SPAN_BIT, 8, size8, ID);
    k_sen = lane_of(addr, SEN_BASE, SPAN_BIT, 8, size8, ID);
    k_cen = lane_of(addr, CEN_BASE, SPAN_BIT, 8, size8, ID);
    k_spd = lane_of(addr, SPD_BASE, SPAN_BIT, 8, size8, ID);
    k_cpd = lane_of(addr, CPD_BASE, SPAN_BIT, 8, size8, ID);
    k_sac = lane_of(addr, SAC_BASE, SPAN_BIT, 8, size8, ID);
    k_cac = lane_of(addr, CAC_BASE, SPAN_BIT, 8, size8, ID);
    k_pri = lane_of(addr, PRI_BASE, SPAN_PRI, 1, size8, ID);
    k_trg = lane_of(addr, TRG_BASE, SPAN_TWO, 4, size8, ID);
    k_gmd = lane_of(addr, GMD_BASE, SPAN_BIT, 8, size8, ID);
    k_nsl = lane_of(addr, NSL_BASE, SPAN_TWO, 4, size8, ID);
    rte_hit = (addr >= RTE_BASE) && (addr < RTE_END) &&
              (int'((addr - RTE_BASE) >> 3) == ID);
  end

  always_comb begin
    nxt     = st;
    sw_pset = 1'b0;
    sw_pclr = 1'b0;
    if (wr_en) begin
      if (k_grp >= 0 && !ns_view) nxt.grp = wdata[6'(k_grp)];
      if (k_sen >= 0 && wdata[6'(k_sen)] && !ns_blocked(sec_off, secure, grp1, st.lvl, NEED_NEVER))
        nxt.en = 1'b1;
      if (k_cen >= 0 && wdata[6'(k_cen)] && !ns_blocked(sec_off, secure, grp1, st.lvl, NEED_NEVER))
        nxt.en = 1'b0;
      sw_pset = k_spd >= 0 && wdata[6'(k_spd)] &&
                !ns_blocked(sec_off, secure, grp1, st.lvl, NEED_SETPEND);
      sw_pclr = k_cpd >= 0 && wdata[6'(k_cpd)] &&
                !ns_blocked(sec_off, secure, grp1, st.lvl, NEED_PENDACT);
      if (k_sac >= 0 && wdata[6'(k_sac)] && !ns_blocked(sec_off, secure, grp1, st.lvl, NEED_PENDACT))
        nxt.act = 1'b1;
      if (k_cac >= 0 && wdata[6'(k_cac)] && !ns_blocked(sec_off, secure, grp1, st.lvl, NEED_PENDACT))
        nxt.act = 1'b0;
      if (k_pri >= 0) begin
        if (!ns_view)  nxt.prio = wdata[6'(8 * k_pri) +: 8];
        else if (grp1) nxt.prio = 8'h80 | (wdata[6'(8 * k_pri) +: 8] >> 1);
      end
      if (k_trg >= 0 && !ns_blocked(sec_off, secure, grp1, st.lvl, NEED_NEVER))
        nxt.edge_trig = wdata[6'(2 * k_trg + 1)];
      if (k_gmd >= 0 && !sec_off && secure) nxt.gmod = wdata[6'(k_gmd)];
      if (k_nsl >= 0 && !sec_off && secure) nxt.lvl = wdata[6'(2 * k_nsl) +: 2];
      if (rte_hit && !ns_blocked(sec_off, secure, grp1, st.lvl, NEED_ROUTE)) begin
        if (size8)                nxt.route = wdata;
        else if (addr[2:0] != 0)  nxt.route[63:32] = wdata[31:0];
        else                      nxt.route[31:0]  = wdata[31:0];
      end
    end
    // software beats hardware; hardware assert beats deassert
    if (sw_pset)      nxt.pend = 1'b1;
    else if (sw_pclr) nxt.pend = 1'b0;
    else if (hw_set)  nxt.pend = 1'b1;
    else if (hw_clr)  nxt.pend = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= '0;
      st.prio <= 8'hAA;
    end else begin
      st <= nxt;
    end
  end

  a_r9_hw_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && !wr_en) |=> st.pend);
  a_r3_ns_group_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !secure && !sec_off && addr >= GRP_BASE && addr < SEN_BASE) |=> $stable(st.grp));
  a_r5_ns_prio_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !secure && !sec_off && k_pri >= 0 && st.grp) |=> st.prio[7]);
  a_r7_low_half_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !size8 && rte_hit && addr[2:0] == 3'd0) |=> $stable(st.route[63:32]));
  a_r4_ns_enable_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !secure && !sec_off && !st.grp && k_sen >= 0) |=> $stable(st.en));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irqcfg_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int SHARED = NUM_LINES - FIRST_SHARED
) (
  input  logic [15:0] addr,
  input  logic        size8,
  input  logic        secure,
  input  logic        sec_off,
  input  irq_state_t  st [SHARED],
  output logic [63:0] rd_data
);
  always_comb begin
    logic [63:0] rd;
    rd = '0;
    for (int j = 0; j < SHARED; j++) begin
      int id, k;
      logic g1, nsv;
      id  = j + FIRST_SHARED;
      g1  = st[j].grp;
      nsv = !sec_off && !secure;
      k = lane_of(addr, GRP_BASE, SPAN_BIT, 8, size8, id);
      if (k >= 0 && !nsv) rd[6'(k)] = g1;
      k = lane_of(addr, SEN_BASE, SPAN_BIT, 8, size8, id);
      if (k >= 0 && !ns_blocked(sec_off, secure, g1, st[j].lvl, NEED_NEVER)) rd[6'(k)] = st[j].en;
      k = lane_of(addr, CEN_BASE, SPAN_BIT, 8, size8, id);
      if (k >= 0 && !ns_blocked(sec_off, secure, g1, st[j].lvl, NEED_NEVER)) rd[6'(k)] = st[j].en;
      k = lane_of(addr, SPD_BASE, SPAN_BIT, 8, size8, id);
      if (k >= 0 && !ns_blocked(sec_off, secure, g1, st[j].lvl, NEED_SETPEND)) rd[6'(k)] = st[j].pend;
      k = lane_of(addr, CPD_BASE, SPAN_BIT, 8, size8, id);
      if (k >= 0 && !ns_blocked(sec_off, secure, g1, st[j].lvl, NEED_PENDACT)) rd[6'(k)] = st[j].pend;
      k = lane_of(addr, SAC_BASE, SPAN_BIT, 8, size8, id);
      if (k >= 0 && !ns_blocked(sec_off, secure, g1, st[j].lvl, NEED_PENDACT)) rd[6'(k)] = st[j].act;
      k = lane_of(addr, CAC_BASE, SPAN_BIT, 8, size8, id);
      if (k >= 0 && !ns_blocked(sec_off, secure, g1, st[j].lvl, NEED_PENDACT)) rd[6'(k)] = st[j].act;
      k = lane_of(addr, PRI_BASE, SPAN_PRI, 1, size8, id);
      if (k >= 0) begin
        if (!nsv)    rd[6'(8 * k) +: 8] = st[j].prio;
        else if (g1) rd[6'(8 * k) +: 8] = {st[j].prio[6:0], 1'b0};
      end
      k = lane_of(addr, TRG_BASE, SPAN_TWO, 4, size8, id);
      if (k >= 0 && !ns_blocked(sec_off, secure, g1, st[j].lvl, NEED_NEVER))
        rd[6'(2 * k + 1)] = st[j].edge_trig;
      k = lane_of(addr, GMD_BASE, SPAN_BIT, 8, size8, id);
      if (k >= 0 && !sec_off && secure) rd[6'(k)] = st[j].gmod;
      k = lane_of(addr, NSL_BASE, SPAN_TWO, 4, size8, id);
      if (k >= 0 && !sec_off && secure) rd[6'(2 * k) +: 2] = st[j].lvl;
      if (addr >= RTE_BASE && addr < RTE_END && int'((addr - RTE_BASE) >> 3) == id &&
          !ns_blocked(sec_off, secure, g1, st[j].lvl, NEED_ROUTE)) begin
        if (size8)               rd = st[j].route;
        else if (addr[2:0] != 0) rd = {32'h0, st[j].route[63:32]};
        else                     rd = {32'h0, st[j].route[31:0]};
      end
    end
    rd_data = rd;
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irqcfg_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int SHARED = NUM_LINES - FIRST_SHARED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_off,
  input  logic              acc_write,
  input  logic [15:0]       acc_addr,
  input  logic              acc_size8,
  input  logic              acc_secure,
  input  logic [63:0]       acc_wdata,
  output logic [63:0]       acc_rdata,
  input  logic [SHARED-1:0] line_assert,
  input  logic [SHARED-1:0] line_deassert,
  output logic [SHARED-1:0] irq_pending,
  output logic [SHARED-1:0] irq_enabled,
  output logic [SHARED-1:0] irq_active
);
  irq_state_t st [SHARED];

  for (genvar j = 0; j < SHARED; j++) begin : g_line
    irq_cell #(.ID(j + FIRST_SHARED)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .sec_off(sec_off),
      .wr_en  (acc_write),
      .addr   (acc_addr),
      .size8  (acc_size8),
      .secure (acc_secure),
      .wdata  (acc_wdata),
      .hw_set (line_assert[j]),
      .hw_clr (line_deassert[j]),
      .st     (st[j])
    );
    assign irq_pending[j] = st[j].pend;
    assign irq_enabled[j] = st[j].en;
    assign irq_active[j]  = st[j].act;
  end

  irq_read_mux #(.NUM_LINES(NUM_LINES)) u_rd (
    .addr   (acc_addr),
    .size8  (acc_size8),
    .secure (acc_secure),
    .sec_off(sec_off),
    .st     (st),
    .rd_data(acc_rdata)
  );
endmodule

// File: tb/test_irq_cfg_regs.sv
module test_irq_cfg_regs;
  localparam int NL = 64;
  localparam int SH = NL - 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sec_off = 1'b0;
  logic          acc_write = 1'b0;
  logic [15:0]   acc_addr = '0;
  logic          acc_size8 = 1'b0;
  logic          acc_secure = 1'b1;
  logic [63:0]   acc_wdata = '0;
  logic [63:0]   acc_rdata;
  logic [SH-1:0] line_assert = '0;
  logic [SH-1:0] line_deassert = '0;
  logic [SH-1:0] irq_pending, irq_enabled, irq_active;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_cfg_regs #(.NUM_LINES(NL)) i_irq_cfg_regs (
    .clk(clk), .rst_n(rst_n), .sec_off(sec_off), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size8(acc_size8), .acc_secure(acc_secure),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .line_assert(line_assert),
    .line_deassert(line_deassert), .irq_pending(irq_pending),
    .irq_enabled(irq_enabled), .irq_active(irq_active)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic        sz8;
    logic        sec;
    logic [63:0] val;
    logic [7:0]  req;
  } op_t;

  localparam int N_OPS = 52;
  localparam op_t OPS [N_OPS] = '{
    '{1'b0, 16'h0104, 1'b0, 1'b1, 64'h0, 8'd1},                 // R1 enable clear
    '{1'b0, 16'h0420, 1'b0, 1'b1, 64'hAAAAAAAA, 8'd1},          // R1 priority 0xAA
    '{1'b0, 16'h0C08, 1'b0, 1'b1, 64'h0, 8'd1},                 // R1 level trigger
    '{1'b1, 16'h0104, 1'b0, 1'b1, 64'h5, 8'd2},                 // R2 set-enable 32,34
    '{1'b0, 16'h0184, 1'b0, 1'b1, 64'h5, 8'd2},
    '{1'b1, 16'h0184, 1'b0, 1'b1, 64'h4, 8'd2},                 // R2 clear-enable 34
    '{1'b0, 16'h0104, 1'b0, 1'b1, 64'h1, 8'd2},
    '{1'b1, 16'h0204, 1'b0, 1'b1, 64'h3, 8'd2},                 // R2 set-pending
    '{1'b0, 16'h0284, 1'b0, 1'b1, 64'h3, 8'd2},
    '{1'b1, 16'h0284, 1'b0, 1'b1, 64'h1, 8'd2},
    '{1'b0, 16'h0204, 1'b0, 1'b1, 64'h2, 8'd2},
    '{1'b1, 16'h0304, 1'b0, 1'b1, 64'h8, 8'd2},                 // R2 active
    '{1'b0, 16'h0384, 1'b0, 1'b1, 64'h8, 8'd2},
    '{1'b1, 16'h0384, 1'b0, 1'b1, 64'h8, 8'd2},
    '{1'b0, 16'h0304, 1'b0, 1'b1, 64'h0, 8'd2},
    '{1'b1, 16'h0084, 1'b0, 1'b0, 64'hFFFF, 8'd3},              // R3 ns group write ignored
    '{1'b0, 16'h0084, 1'b0, 1'b1, 64'h0, 8'd3},
    '{1'b1, 16'h0084, 1'b0, 1'b1, 64'h1, 8'd3},                 // R3 line 32 to group 1
    '{1'b0, 16'h0084, 1'b0, 1'b1, 64'h1, 8'd3},
    '{1'b0, 16'h0084, 1'b0, 1'b0, 64'h0, 8'd3},
    '{1'b0, 16'h0420, 1'b0, 1'b0, 64'h54, 8'd5},                // R5 ns priority view
    '{1'b1, 16'h0420, 1'b0, 1'b0, 64'h11223344, 8'd5},
    '{1'b0, 16'h0420, 1'b0, 1'b1, 64'hAAAAAAA2, 8'd5},
    '{1'b1, 16'h0C08, 1'b0, 1'b1, 64'h2, 8'd6},                 // R6 edge
    '{1'b0, 16'h0C08, 1'b0, 1'b1, 64'h2, 8'd6},
    '{1'b1, 16'h0C08, 1'b0, 1'b1, 64'h1, 8'd6},                 // R6 lower bit only
    '{1'b0, 16'h0C08, 1'b0, 1'b1, 64'h0, 8'd6},
    '{1'b1, 16'h6100, 1'b1, 1'b1, 64'h1122334455667788, 8'd7},  // R7 full word
    '{1'b0, 16'h6100, 1'b0, 1'b1, 64'h55667788, 8'd7},
    '{1'b0, 16'h6104, 1'b0, 1'b1, 64'h11223344, 8'd7},
    '{1'b1, 16'h6104, 1'b0, 1'b1, 64'hDEADBEEF, 8'd7},
    '{1'b0, 16'h6100, 1'b1, 1'b1, 64'hDEADBEEF55667788, 8'd7},
    '{1'b1, 16'h0E08, 1'b0, 1'b0, 64'hFF, 8'd3},                // R3 ns level write ignored
    '{1'b0, 16'h0E08, 1'b0, 1'b1, 64'h0, 8'd3},
    '{1'b1, 16'h0E08, 1'b0, 1'b1, 64'h4, 8'd4},                 // R4 line 33 level 1
    '{1'b0, 16'h0E08, 1'b0, 1'b1, 64'h4, 8'd3},
    '{1'b0, 16'h0E08, 1'b0, 1'b0, 64'h0, 8'd3},
    '{1'b0, 16'h0204, 1'b0, 1'b0, 64'h2, 8'd4},                 // R4 level 1 shows set-pend
    '{1'b0, 16'h0284, 1'b0, 1'b0, 64'h0, 8'd4},                 // R4 but not clear-pend
    '{1'b1, 16'h0284, 1'b0, 1'b0, 64'h2, 8'd4},
    '{1'b0, 16'h0204, 1'b0, 1'b1, 64'h2, 8'd4},
    '{1'b1, 16'h0104, 1'b0, 1'b0, 64'h2, 8'd4},                 // R4 ns enable blocked
    '{1'b0, 16'h0104, 1'b0, 1'b1, 64'h1, 8'd4},
    '{1'b0, 16'h0100, 1'b1, 1'b1, 64'h0, 8'd8},                 // R8 first line below 32
    '{1'b0, 16'h0104, 1'b1, 1'b1, 64'h1, 8'd8},
    '{1'b1, 16'h0100, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFF, 8'd8},
    '{1'b0, 16'h0104, 1'b1, 1'b1, 64'h1, 8'd8},
    '{1'b1, 16'h0800, 1'b0, 1'b1, 64'hFFFFFFFF, 8'd10},         // R10 legacy window
    '{1'b0, 16'h0800, 1'b0, 1'b1, 64'h0, 8'd10},
    '{1'b1, 16'h6108, 1'b1, 1'b1, 64'hAB, 8'd4},                // R4 routing needs level 3
    '{1'b0, 16'h6108, 1'b1, 1'b0, 64'h0, 8'd4},
    '{1'b0, 16'h6108, 1'b1, 1'b1, 64'hAB, 8'd4}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic s8, input logic sec,
                          input logic [63:0] d);
    @(negedge clk);
    acc_write = 1'b1; acc_addr = a; acc_size8 = s8; acc_secure = sec; acc_wdata = d;
    @(negedge clk);
    acc_write = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic s8, input logic sec,
                         input logic [63:0] exp, input string tag);
    @(negedge clk);
    acc_write = 1'b0; acc_addr = a; acc_size8 = s8; acc_secure = sec;
    #5;
    chk(tag, acc_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1 pending vector", 64'(irq_pending), 64'h0);
    chk("R1 active vector", 64'(irq_active), 64'h0);

    for (int n = 0; n < N_OPS; n++) begin
      if (OPS[n].wr) do_write(OPS[n].addr, OPS[n].sz8, OPS[n].sec, OPS[n].val);
      else do_read(OPS[n].addr, OPS[n].sz8, OPS[n].sec, OPS[n].val,
                   $sformatf("R%0d table entry %0d", OPS[n].req, n));
    end

    chk("R2 enabled vector", 64'(irq_enabled), 64'h1);
    // R8 lines at or above NUM_LINES read zero
    do_read(16'h0108, 1'b0, 1'b1, 64'h0, "R8 beyond line count");

    // R9 hardware assert sets pending on line 40
    @(negedge clk); line_assert[8] = 1'b1;
    @(negedge clk); line_assert[8] = 1'b0;
    chk("R9 hw assert", 64'(irq_pending[8]), 64'h1);
    do_read(16'h0204, 1'b0, 1'b1, 64'h102, "R9 pending readback");
    // R9 software clear wins over hardware assert in the same cycle
    line_assert[8] = 1'b1;
    do_write(16'h0284, 1'b0, 1'b1, 64'h100);
    line_assert[8] = 1'b0;
    chk("R9 sw clear beats hw assert", 64'(irq_pending[8]), 64'h0);
    // R9 software set wins over hardware deassert
    line_deassert[8] = 1'b1;
    do_write(16'h0204, 1'b0, 1'b1, 64'h100);
    line_deassert[8] = 1'b0;
    chk("R9 sw set beats hw deassert", 64'(irq_pending[8]), 64'h1);
    @(negedge clk); line_deassert[8] = 1'b1;
    @(negedge clk); line_deassert[8] = 1'b0;
    chk("R9 hw deassert", 64'(irq_pending[8]), 64'h0);

    // Single security state
    sec_off = 1'b1;
    do_write(16'h0084, 1'b0, 1'b0, 64'h3);
    do_read(16'h0084, 1'b0, 1'b0, 64'h3, "R3 group open when security off");
    do_write(16'h0D04, 1'b0, 1'b1, 64'h1);
    do_read(16'h0D04, 1'b0, 1'b1, 64'h0, "R3 modifier closed when security off");
    do_read(16'h0E08, 1'b0, 1'b1, 64'h0, "R3 level closed when security off");
    do_read(16'h0420, 1'b0, 1'b0, 64'hAAAAAAA2, "R5 no shift when security off");

    sec_off = 1'b0;
    do_write(16'h0D04, 1'b0, 1'b1, 64'h4);
    do_read(16'h0D04, 1'b0, 1'b1, 64'h4, "R3 modifier secure write");
    do_read(16'h0D04, 1'b0, 1'b0, 64'h0, "R3 modifier ns read");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule